// File: doc/BRIEF.md
# UART Receive Buffer with Status Words

This block sits between a UART deserialiser and the register interface of a serial port. It takes in bytes from the receiver, one per cycle, along with line-break events and per-byte error flags, and stores them until the CPU reads them. It reports occupancy, data availability and line errors as status words. A control bit chooses between two storage modes. In the first mode the bytes go into a circular FIFO whose depth is a parameter (16 by default). In the second mode a single holding register keeps only the most recent byte.

The CPU side consists of read strobes. One strobe reads the data register and the other reads the error-status word. There is also a control write port that sets the mode and can empty the FIFO. The block drives two single-cycle event pulses toward an interrupt controller: one for each accepted byte and one for receive errors. Baud timing, deserialisation and bus decoding are handled elsewhere.

Top module: `uart_rx_buffer`

## Requirements
- R1: While reset is held and immediately after it, these outputs are all 0: ctrl_rdata_o, rdata_o, ready_o, fifo_stat_o, err_stat_o and both event pulses.
- R2: In FIFO mode (control bit 0 = 1), bytes are read out in arrival order, and rdata_o always shows the oldest stored byte. A push and a pop in the same cycle are both carried out. ready_o is 1 while any byte is stored and goes to 0 after the read that empties the FIFO.
- R3: fifo_stat_o carries the stored-byte count in bits [7:0] and a full flag in bit 8. Bit 9 is set whenever any error-status bit is set. When the FIFO is full, bits [7:0] read 0 and bit 8 reads 1.
- R4: A byte that arrives while the FIFO is full is dropped, even if a read happens in the same cycle. The cycle after, err_evt_o pulses. The stored contents do not change and ready_o stays 1.
- R5: In FIFO mode, reading the data register while the FIFO is empty returns 0 on rdata_o, and err_evt_o pulses one cycle later.
- R6: A control write with bit 1 set empties the FIFO. Bit 1 is not stored and always reads back as 0, while bit 0 keeps the value that was written.
- R7: A break event (brk_i) stores a 0x00 byte and sets error-status bit 3. It does not pulse rx_evt_o.
- R8: The error-status word is sticky, with overrun in bit 0, parity in bit 1, frame in bit 2 and break in bit 3. rx_err_i[2:0] sets bits 0 to 2. A read strobe clears the word in the next cycle, except for bits that are set in that same cycle.
- R9: With control bit 0 = 0, every received byte overwrites the holding register and sets ready_o. A data read clears ready_o. Reading when no byte is held raises no error event.
- R10: Each accepted byte produces a one-cycle pulse on rx_evt_o in the following cycle, in both modes.
- R11: If a break and a byte arrive in the same cycle, the break is stored, the byte is dropped and err_evt_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Control write data: bit 0 FIFO mode, bit 1 empty FIFO |
| ctrl_rdata_o | output | 2 | Control readback (bit 1 always 0) |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Receiver error flags: overrun, parity, frame |
| brk_i | input | 1 | Line-break event |
| rd_data_i | input | 1 | CPU read of the data register |
| rd_err_i | input | 1 | CPU read of the error-status word |
| rdata_o | output | 8 | Data register read value |
| ready_o | output | 1 | Receive data ready |
| fifo_stat_o | output | 10 | FIFO status word |
| err_stat_o | output | 4 | Error-status word |
| rx_evt_o | output | 1 | Receive event pulse |
| err_evt_o | output | 1 | Receive error event pulse |

## Verification
The buffer is driven with several patterns: short bursts that are read back one at a time, a fill to exactly the depth followed by one extra byte, and a push and pop in the same cycle. These separate the occupancy counting from the wrap of the pointers and show that the zero-count/full encoding is correct. Other patterns cover an empty read, a flush while data is stored, and a break both on its own and together with a byte, which shows the difference between the data path and the error path. Error flags that arrive in the same cycle as a status read check the clear-on-read precedence. Finally, the holding-register mode gets back-to-back bytes and repeated reads, which shows overwrite rather than queueing.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 8;
  localparam int ERR_W     = 4;
  localparam int ERR_BRK   = 3;
  localparam int CTL_EN    = 0;
  localparam int CTL_FLUSH = 1;
  localparam int STAT_FULL = 8;
  localparam int STAT_ERR  = 9;
  localparam int STAT_W    = 10;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R6
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rxb_err_status.sv
module rxb_err_status #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[b] <= 1'b0;
      else if (clr_i)    q[b] <= set_i[b];
      else if (set_i[b]) q[b] <= 1'b1;
    end
  end

  assign word_o = q;

  // R8
  clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> word_o == '0);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (word_o & $past(word_o)) == $past(word_o));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [1:0]        ctrl_wdata_i,
  output logic [1:0]        ctrl_rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [2:0]        rx_err_i,
  input  logic              brk_i,
  input  logic              rd_data_i,
  input  logic              rd_err_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic [STAT_W-1:0] fifo_stat_o,
  output logic [ERR_W-1:0]  err_stat_o,
  output logic              rx_evt_o,
  output logic              err_evt_o
);
  logic              en_q, hvld_q, rx_evt_q, err_evt_q;
  logic [DATA_W-1:0] hold_q, head, wval;
  logic [CW-1:0]     cnt;
  logic              full, empty, flush, want, clash;
  logic              f_push, f_pop, drop, empty_rd, rx_acc;

  assign flush    = ctrl_we_i & ctrl_wdata_i[CTL_FLUSH];
  assign want     = brk_i | rx_valid_i;
  assign clash    = brk_i & rx_valid_i;
  assign wval     = brk_i ? '0 : rx_data_i;
  assign f_push   = en_q & want & ~full & ~flush;
  assign f_pop    = en_q & rd_data_i & ~empty & ~flush;
  assign drop     = en_q & want & full & ~flush;
  assign empty_rd = en_q & rd_data_i & empty;
  assign rx_acc   = rx_valid_i & ~brk_i & (~en_q | (~full & ~flush));

  rxb_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (f_push),
    .pop_i   (f_pop),
    .wdata_i (wval),
    .head_o  (head),
    .count_o (cnt),
    .full_o  (full),
    .empty_o (empty)
  );

  rxb_err_status #(.W(ERR_W)) u_err (
    .clk_i, .rst_ni,
    .set_i  ({brk_i, rx_err_i}),
    .clr_i  (rd_err_i),
    .word_o (err_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      hold_q    <= '0;
      hvld_q    <= 1'b0;
      rx_evt_q  <= 1'b0;
      err_evt_q <= 1'b0;
    end else begin
      if (ctrl_we_i) en_q <= ctrl_wdata_i[CTL_EN];
      if (!en_q && want) begin
        hold_q <= wval;
        hvld_q <= 1'b1;
      end else if (!en_q && rd_data_i) begin
        hvld_q <= 1'b0;
      end
      rx_evt_q  <= rx_acc;
      err_evt_q <= clash | drop | empty_rd;
    end
  end

  assign ctrl_rdata_o = {1'b0, en_q};
  assign ready_o      = en_q ? ~empty : hvld_q;
  assign rdata_o      = en_q ? (empty ? '0 : head) : hold_q;
  assign fifo_stat_o  = {|err_stat_o, full, full ? CNT_W'(0) : CNT_W'(cnt)};
  assign rx_evt_o     = rx_evt_q;
  assign err_evt_o    = err_evt_q;

  // R7
  brk_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && brk_i && !full && !flush && !ctrl_we_i) |=> (ready_o && err_stat_o[ERR_BRK]));
  // R9
  hold_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_we_i && rx_valid_i && !brk_i) |=> (ready_o && rdata_o == $past(rx_data_i)));
  // R5
  empty_read_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && rd_data_i && !ready_o) |=> err_evt_o);
  // R10
  rx_evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_valid_i) |=> !rx_evt_o);
endmodule

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;
  localparam int L_DEPTH = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ctrl_we = 0, rx_valid = 0, brk = 0, rd_data = 0, rd_err = 0;
  logic [1:0] ctrl_wdata = 0, ctrl_rdata;
  logic [7:0] rx_data = 0, rdata;
  logic [2:0] rx_err = 0;
  logic       ready, rx_evt, err_evt;
  logic [9:0] fifo_stat;
  logic [3:0] err_stat;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_buffer #(.DEPTH(L_DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err), .brk_i(brk),
    .rd_data_i(rd_data), .rd_err_i(rd_err),
    .rdata_o(rdata), .ready_o(ready), .fifo_stat_o(fifo_stat), .err_stat_o(err_stat),
    .rx_evt_o(rx_evt), .err_evt_o(err_evt)
  );

  // reference model
  byte unsigned q[$];
  bit   m_en, m_hvld, m_rx_evt, m_err_evt;
  byte unsigned m_hold;
  bit [3:0] m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_en = 0; m_hvld = 0; m_hold = 0; m_err = 0;
      m_rx_evt = 0; m_err_evt = 0;
    end else begin
      bit want, is_full, fl, rx_ev, er_ev;
      byte unsigned v;
      want    = brk | rx_valid;
      v       = brk ? 8'h00 : rx_data;
      is_full = (q.size() == L_DEPTH);
      fl      = ctrl_we & ctrl_wdata[1];
      rx_ev   = 0;
      er_ev   = brk & rx_valid;
      if (m_en) begin
        if (rd_data && q.size() == 0) er_ev = 1;
        if (fl) q.delete();
        else begin
          if (rd_data && q.size() > 0) void'(q.pop_front());
          if (want) begin
            if (!is_full) begin q.push_back(v); rx_ev = rx_valid & ~brk; end
            else er_ev = 1;
          end
        end
      end else begin
        if (fl) q.delete();
        if (want) begin m_hold = v; m_hvld = 1; rx_ev = rx_valid & ~brk; end
        else if (rd_data) m_hvld = 0;
      end
      m_err = (rd_err ? 4'h0 : m_err) | {brk, rx_err};
      if (ctrl_we) m_en = ctrl_wdata[0];
      m_rx_evt = rx_ev; m_err_evt = er_ev;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int c; bit f; int e_rd, e_stat;
    c = q.size(); f = (c == L_DEPTH);
    e_stat = {(|m_err), f, f ? 8'h00 : 8'(c)};
    e_rd   = m_en ? (c > 0 ? int'(q[0]) : 0) : int'(m_hold);
    chk("R2", "rdata", rdata, e_rd);
    chk("R2", "ready", ready, m_en ? (c > 0) : m_hvld);
    chk("R3", "fifo_stat", fifo_stat, e_stat);
    chk("R8", "err_stat", err_stat, m_err);
    chk("R6", "ctrl_rdata", ctrl_rdata, {1'b0, m_en});
    chk("R10", "rx_evt", rx_evt, m_rx_evt);
    chk("R4", "err_evt", err_evt, m_err_evt);
  end

  task automatic act(bit we, bit [1:0] wd, bit rv, byte unsigned d, bit b,
                     bit [2:0] fl, bit rd, bit rde);
    @(negedge clk);
    ctrl_we = we; ctrl_wdata = wd; rx_valid = rv; rx_data = d; brk = b;
    rx_err = fl; rd_data = rd; rd_err = rde;
  endtask
  task automatic idle();          act(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic push(byte unsigned d); act(0, 0, 1, d, 0, 0, 0, 0); endtask
  task automatic rd();            act(0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic ctl(bit [1:0] w); act(1, w, 0, 0, 0, 0, 0, 0); endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "stat in reset", fifo_stat, 0);
    rst_n = 1'b1;
    idle();
    chk("R1", "rdata after reset", rdata, 0);
    chk("R1", "err after reset", err_stat, 0);

    ctl(2'b01); idle();
    chk("R6", "ctrl readback", ctrl_rdata, 1);

    push(8'h11); push(8'h22); push(8'h33); idle();
    chk("R3", "count 3", fifo_stat, 3);
    chk("R10", "rx_evt after push", rx_evt, 1);
    rd(); idle();
    chk("R2", "second byte at head", rdata, 8'h22);
    rd(); rd(); idle();
    chk("R2", "ready cleared when emptied", ready, 0);

    for (int i = 0; i < L_DEPTH; i++) push(8'(i * 3 + 1));
    idle();
    chk("R3", "full encoding", fifo_stat, 10'h100);
    push(8'hEE); idle();
    chk("R4", "overflow err_evt", err_evt, 1);
    chk("R4", "ready held on overflow", ready, 1);
    chk("R4", "stat unchanged", fifo_stat, 10'h100);
    act(0, 0, 1, 8'hEF, 0, 0, 1, 0); idle();
    chk("R4", "drop with read when full", fifo_stat, 15);
    chk("R4", "head after drop", rdata, 4);
    for (int i = 0; i < L_DEPTH - 1; i++) rd();
    idle();
    rd(); idle();
    chk("R5", "empty read data", rdata, 0);
    chk("R5", "empty read err_evt", err_evt, 1);

    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    ctl(2'b11); idle();
    chk("R6", "flush bit not stored", ctrl_rdata, 1);
    chk("R6", "flush empties", fifo_stat, 0);

    act(0, 0, 0, 0, 1, 0, 0, 0); idle();
    chk("R7", "break stores null", rdata, 0);
    chk("R7", "break ready", ready, 1);
    chk("R7", "break err bit", err_stat, 4'h8);
    chk("R7", "break status", fifo_stat, 10'h201);
    chk("R7", "no rx_evt on break", rx_evt, 0);

    act(0, 0, 0, 0, 0, 3'b101, 0, 0); idle();
    chk("R8", "sticky flags", err_stat, 4'hD);
    act(0, 0, 0, 0, 0, 0, 0, 1); idle();
    chk("R8", "clear on read", err_stat, 0);
    act(0, 0, 0, 0, 0, 3'b010, 0, 1); idle();
    chk("R8", "set wins over clear", err_stat, 4'h2);
    act(0, 0, 0, 0, 0, 0, 1, 1); idle();

    act(0, 0, 1, 8'h55, 1, 0, 0, 0); idle();
    chk("R11", "clash err_evt", err_evt, 1);
    chk("R11", "clash stores null", fifo_stat, 10'h201);
    chk("R11", "clash rx_evt", rx_evt, 0);
    act(0, 0, 0, 0, 0, 0, 1, 1);

    push(8'h71); act(0, 0, 1, 8'h72, 0, 0, 1, 0); idle();
    chk("R2", "push+pop head", rdata, 8'h72);
    chk("R2", "push+pop count", fifo_stat, 1);
    rd();

    ctl(2'b00);
    push(8'h61); push(8'h62); idle();
    chk("R9", "hold overwrite", rdata, 8'h62);
    chk("R9", "hold ready", ready, 1);
    chk("R10", "rx_evt hold mode", rx_evt, 1);
    rd(); idle();
    chk("R9", "hold read clears ready", ready, 0);
    rd(); idle();
    chk("R9", "no err on empty hold read", err_evt, 0);
    idle(); idle();

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule